// File: doc/BRIEF.md
# Redundant PCM Line Comparator

This block watches two pairs of serial PCM receive lines that are expected to carry the same traffic. Lines 0 and 1 form one pair, and lines 2 and 3 form the other. One bit of each line is sampled on every rising clock edge. A frame-sync strobe marks the first bit of time slot 0. Each time slot holds eight bits.

The two lines of a pair are compared bit by bit. At the end of each slot the block decides whether that slot differed on each pair. A slot that differed raises a mismatch flag, and the block records which pair failed and the slot number. The recorded report is kept until software acknowledges the flag with a read strobe.

If both pairs fail in the same slot, the lower pair is reported first. The report for the other pair is queued and presented on the next acknowledgement. Comparison works the same way whatever line set the surrounding receiver uses. The pairing is fixed, and choosing which line of a pair feeds the switching path belongs to other logic.

Top module: `pcm_pair_cmp`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `mism_irq` is 0 and `cap_pair` and `cap_slot` are 0.
- R2: When both lines of every pair carry identical bits, `mism_irq` stays 0.
- R3: A difference in any single one of the eight bits of a slot, between `rx_lines[2k]` and `rx_lines[2k+1]`, sets `mism_irq`.
- R4: On a new report, `cap_pair` holds the pair number k: 0 for lines 0/1 and 1 for lines 2/3. `cap_slot` holds the slot number, counted from the bit sampled with `fsync` high, which is bit 0 of slot 0.
- R5: The flag and capture update on the first rising edge after the edge that samples the last (eighth) bit of the failing slot. They do not update before that edge.
- R6: While `mism_irq` is high and no `stat_rd` is given, later mismatches do not change `cap_pair` or `cap_slot`.
- R7: A `stat_rd` pulse with no queued report clears `mism_irq` at that edge.
- R8: If both pairs fail in one slot, pair 0 is reported. The pair-1 report for the same slot is queued. The next `stat_rd` keeps `mism_irq` high and loads `cap_pair`=1 with the same `cap_slot`.
- R9: Bits sampled while `cmp_en` is 0 never count as differences.
- R10: `fsync` restarts the count at slot 0 bit 0 at any point, and any partial slot is discarded. Without `fsync`, the slot number wraps from NUM_SLOTS-1 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one data bit per line per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | High on the bit that is slot 0, bit 0 |
| rx_lines | input | 2*NUM_PAIRS | Serial receive lines; lines 2k and 2k+1 form pair k |
| cmp_en | input | 1 | Comparison enable, sampled per bit |
| stat_rd | input | 1 | Status read strobe; acknowledges the current report |
| mism_irq | output | 1 | Mismatch flag |
| cap_pair | output | PAIR_W | Number of the pair in the held report |
| cap_slot | output | SLOT_W | Slot number of the held report |

## Verification
The case hardest to reach from the ports is two pairs failing in the very same slot, followed by the hand-off of the queued second report during a read. The bench builds frames that flip one chosen bit on each pair independently. It places both flips in one slot and then issues two reads in a row.

The slot counter is also driven out of step on purpose. Idle bits are inserted before a new frame sync, and one frame is sent with no sync at all. This exercises both realignment and the wrap of the slot number.

// File: rtl/pcm_cmp_pkg.sv
package pcm_cmp_pkg;

  localparam int BITS_PER_SLOT = 8;
  localparam int BIT_W = $clog2(BITS_PER_SLOT);

  // Next-state choice of the report register
  typedef enum logic [1:0] {
    ACT_HOLD,
    ACT_CLEAR,
    ACT_LOAD_NEW,
    ACT_LOAD_PEND
  } cap_act_e;

endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
  import pcm_cmp_pkg::*;
#(
  parameter int NUM_SLOTS = 32,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              first_bit,
  output logic              last_bit
);

  logic [BIT_W-1:0]  bit_q;
  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  cur_bit;

  // Frame sync forces the present bit to slot 0, bit 0
  always_comb begin
    cur_bit   = fsync ? '0 : bit_q;
    cur_slot  = fsync ? '0 : slot_q;
    first_bit = (cur_bit == '0);
    last_bit  = (cur_bit == BIT_W'(BITS_PER_SLOT - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q  <= '0;
      slot_q <= '0;
    end else if (last_bit) begin
      bit_q  <= '0;
      slot_q <= (cur_slot == SLOT_W'(NUM_SLOTS - 1)) ? '0 : cur_slot + SLOT_W'(1);
    end else begin
      bit_q  <= cur_bit + BIT_W'(1);
      slot_q <= cur_slot;
    end
  end

endmodule

// File: rtl/pcm_pair_acc.sv
module pcm_pair_acc (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic line_a,
  input  logic line_b,
  input  logic first_bit,
  input  logic last_bit,
  output logic slot_bad
);

  logic acc_q;
  logic diff;
  logic merged;

  // The first bit of a slot drops whatever was gathered before it
  always_comb begin
    diff     = en & (line_a ^ line_b);
    merged   = (first_bit ? 1'b0 : acc_q) | diff;
    slot_bad = merged;
  end

  always_ff @(posedge clk) begin
    if (rst)           acc_q <= 1'b0;
    else if (last_bit) acc_q <= 1'b0;
    else               acc_q <= merged;
  end

endmodule

// File: rtl/pcm_cap_ctrl.sv
module pcm_cap_ctrl
  import pcm_cmp_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int PAIR_W = 1,
  parameter int SLOT_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PAIRS-1:0] ev_mask,
  input  logic [SLOT_W-1:0]    ev_slot,
  input  logic                 stat_rd,
  output logic                 irq,
  output logic [PAIR_W-1:0]    cap_pair,
  output logic [SLOT_W-1:0]    cap_slot,
  output logic                 pend_any
);

  logic [NUM_PAIRS-1:0] pend_q;
  logic [SLOT_W-1:0]    pend_slot_q;
  logic [NUM_PAIRS-1:0] new_oh;
  logic [NUM_PAIRS-1:0] pend_oh;
  logic [PAIR_W-1:0]    new_idx;
  logic [PAIR_W-1:0]    pend_idx;
  cap_act_e             act;

  // Lowest pair number wins: isolate the lowest set bit
  always_comb begin
    new_oh  = ev_mask & (~ev_mask + NUM_PAIRS'(1));
    pend_oh = pend_q & (~pend_q + NUM_PAIRS'(1));
    new_idx  = '0;
    pend_idx = '0;
    for (int i = 0; i < NUM_PAIRS; i++) begin
      if (new_oh[i])  new_idx  = PAIR_W'(i);
      if (pend_oh[i]) pend_idx = PAIR_W'(i);
    end
    pend_any = |pend_q;
  end

  always_comb begin
    if (stat_rd && pend_any)                  act = ACT_LOAD_PEND;
    else if ((|ev_mask) && (!irq || stat_rd)) act = ACT_LOAD_NEW;
    else if (stat_rd)                         act = ACT_CLEAR;
    else                                      act = ACT_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq         <= 1'b0;
      cap_pair    <= '0;
      cap_slot    <= '0;
      pend_q      <= '0;
      pend_slot_q <= '0;
    end else begin
      case (act)
        ACT_LOAD_PEND: begin
          irq      <= 1'b1;
          cap_pair <= pend_idx;
          cap_slot <= pend_slot_q;
          pend_q   <= pend_q & ~pend_oh;
        end
        ACT_LOAD_NEW: begin
          irq         <= 1'b1;
          cap_pair    <= new_idx;
          cap_slot    <= ev_slot;
          pend_q      <= ev_mask & ~new_oh;
          pend_slot_q <= ev_slot;
        end
        ACT_CLEAR: irq <= 1'b0;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/pcm_pair_cmp.sv
module pcm_pair_cmp
  import pcm_cmp_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  parameter int NUM_SLOTS = 32,
  localparam int PAIR_W = (NUM_PAIRS <= 2) ? 1 : $clog2(NUM_PAIRS),
  localparam int SLOT_W = (NUM_SLOTS <= 2) ? 1 : $clog2(NUM_SLOTS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   fsync,
  input  logic [2*NUM_PAIRS-1:0] rx_lines,
  input  logic                   cmp_en,
  input  logic                   stat_rd,
  output logic                   mism_irq,
  output logic [PAIR_W-1:0]      cap_pair,
  output logic [SLOT_W-1:0]      cap_slot
);

  logic [SLOT_W-1:0]    cur_slot;
  logic                 first_bit;
  logic                 last_bit;
  logic [NUM_PAIRS-1:0] bad_vec;
  logic [NUM_PAIRS-1:0] ev_mask_q;
  logic [SLOT_W-1:0]    ev_slot_q;
  logic                 pend_any;

  pcm_slot_timer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) timer_i (
    .clk(clk), .rst(rst), .fsync(fsync),
    .cur_slot(cur_slot), .first_bit(first_bit), .last_bit(last_bit)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    pcm_pair_acc acc_i (
      .clk(clk), .rst(rst), .en(cmp_en),
      .line_a(rx_lines[2*p]), .line_b(rx_lines[2*p+1]),
      .first_bit(first_bit), .last_bit(last_bit),
      .slot_bad(bad_vec[p])
    );
  end

  // Slot verdict stage: one cycle pulse per finished slot
  always_ff @(posedge clk) begin
    if (rst) begin
      ev_mask_q <= '0;
      ev_slot_q <= '0;
    end else begin
      ev_mask_q <= last_bit ? bad_vec : '0;
      if (last_bit) ev_slot_q <= cur_slot;
    end
  end

  pcm_cap_ctrl #(.NUM_PAIRS(NUM_PAIRS), .PAIR_W(PAIR_W), .SLOT_W(SLOT_W)) cap_i (
    .clk(clk), .rst(rst), .ev_mask(ev_mask_q), .ev_slot(ev_slot_q),
    .stat_rd(stat_rd), .irq(mism_irq), .cap_pair(cap_pair),
    .cap_slot(cap_slot), .pend_any(pend_any)
  );

endmodule

// File: rtl/pcm_pair_cmp_chk.sv
module pcm_pair_cmp_chk #(
  parameter int NUM_PAIRS = 2,
  parameter int NUM_SLOTS = 32,
  parameter int PAIR_W = 1,
  parameter int SLOT_W = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 stat_rd,
  input logic                 irq,
  input logic [PAIR_W-1:0]    cap_pair,
  input logic [SLOT_W-1:0]    cap_slot,
  input logic [NUM_PAIRS-1:0] ev_mask,
  input logic                 pend_any
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (!irq && cap_slot == '0));

  // R3
  flag_sets_chk: assert property (@(posedge clk) disable iff (rst)
    ((|ev_mask) && !irq) |=> irq);

  // R4
  slot_range_chk: assert property (@(posedge clk) disable iff (rst)
    cap_slot <= SLOT_W'(NUM_SLOTS - 1));

  // R6
  report_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !stat_rd) |=> (irq && $stable(cap_pair) && $stable(cap_slot)));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && stat_rd && !pend_any && !(|ev_mask)) |=> !irq);

  // R8
  low_pair_first_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq && ev_mask[0]) |=> (irq && cap_pair == '0));

endmodule

bind pcm_pair_cmp pcm_pair_cmp_chk #(
  .NUM_PAIRS(NUM_PAIRS), .NUM_SLOTS(NUM_SLOTS), .PAIR_W(PAIR_W), .SLOT_W(SLOT_W)
) chk_i (
  .clk(clk), .rst(rst), .stat_rd(stat_rd), .irq(mism_irq),
  .cap_pair(cap_pair), .cap_slot(cap_slot),
  .ev_mask(ev_mask_q), .pend_any(pend_any)
);

// File: tb/pcm_pair_cmp_tb.sv
module pcm_pair_cmp_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int SLOTS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fsync = 1'b0;
  logic [3:0] rx = '0;
  logic       cmp_en = 1'b1;
  logic       stat_rd = 1'b0;
  logic       irq;
  logic [0:0] cap_pair;
  logic [1:0] cap_slot;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pcm_pair_cmp #(.NUM_PAIRS(2), .NUM_SLOTS(SLOTS)) dut_i (
    .clk(clk), .rst(rst), .fsync(fsync), .rx_lines(rx), .cmp_en(cmp_en),
    .stat_rd(stat_rd), .mism_irq(irq), .cap_pair(cap_pair), .cap_slot(cap_slot)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive one bit time, then wait past the edge that samples it
  task automatic tick(input logic fs, input logic [3:0] d, input logic en, input logic rd);
    fsync = fs; rx = d; cmp_en = en; stat_rd = rd;
    @(negedge clk);
    fsync = 1'b0; stat_rd = 1'b0;
  endtask

  // One frame; pair k differs at (ik_s, ik_b) when those are not negative
  task automatic send_frame(input int i0s, input int i0b, input int i1s, input int i1b,
                            input logic en, input logic use_fs);
    for (int s = 0; s < SLOTS; s++) begin
      for (int b = 0; b < 8; b++) begin
        logic [3:0] d;
        for (int p = 0; p < 2; p++) begin
          logic [7:0] base;
          logic v, inj;
          base = 8'((s * 29 + p * 83 + 5) & 255);
          v = base[7 - b];
          inj = (p == 0) ? (i0s == s && i0b == b) : (i1s == s && i1b == b);
          d[2*p] = v;
          d[2*p+1] = v ^ inj;
        end
        tick(use_fs && s == 0 && b == 0, d, en, 1'b0);
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 4'b0000, 1'b1, 1'b0);
  endtask

  task automatic read_status();
    tick(1'b0, 4'b0000, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq", irq, 0);
    check("R1 pair", cap_pair, 0);
    check("R1 slot", cap_slot, 0);
    rst = 1'b0;

    // R2: identical lines
    send_frame(-1, -1, -1, -1, 1'b1, 1'b1);
    idle(2);
    check("R2 irq", irq, 0);

    // R3/R4: every pair, slot and bit position
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < SLOTS; s++) begin
        for (int b = 0; b < 8; b++) begin
          if (p == 0) send_frame(s, b, -1, -1, 1'b1, 1'b1);
          else        send_frame(-1, -1, s, b, 1'b1, 1'b1);
          idle(2);
          check("R3 irq", irq, 1);
          check("R4 pair", cap_pair, p);
          check("R4 slot", cap_slot, s);
          read_status();
          check("R7 clear", irq, 0);
        end
      end
    end

    // R5: update one edge after the last bit of the slot
    send_frame(-1, -1, SLOTS - 1, 7, 1'b1, 1'b1);
    check("R5 not yet", irq, 0);
    idle(1);
    check("R5 set", irq, 1);
    check("R5 slot", cap_slot, SLOTS - 1);
    read_status();

    // R6: first report held
    send_frame(1, 2, 2, 6, 1'b1, 1'b1);
    send_frame(-1, -1, 0, 0, 1'b1, 1'b1);
    idle(2);
    check("R6 pair", cap_pair, 0);
    check("R6 slot", cap_slot, 1);
    read_status();
    check("R7 clear after hold", irq, 0);

    // R8: both pairs in one slot
    send_frame(2, 3, 2, 5, 1'b1, 1'b1);
    idle(2);
    check("R8 first pair", cap_pair, 0);
    check("R8 first slot", cap_slot, 2);
    read_status();
    check("R8 irq kept", irq, 1);
    check("R8 queued pair", cap_pair, 1);
    check("R8 queued slot", cap_slot, 2);
    read_status();
    check("R8 final clear", irq, 0);

    // R9: comparison disabled
    send_frame(1, 4, 3, 0, 1'b0, 1'b1);
    idle(2);
    check("R9 irq", irq, 0);

    // R10: realignment after stray bits
    idle(13);
    send_frame(-1, -1, 0, 0, 1'b1, 1'b1);
    idle(2);
    check("R10 realign slot", cap_slot, 0);
    check("R10 realign pair", cap_pair, 1);
    read_status();

    // R10: wrap without frame sync
    send_frame(-1, -1, -1, -1, 1'b1, 1'b1);
    send_frame(2, 0, -1, -1, 1'b1, 1'b0);
    idle(2);
    check("R10 wrap irq", irq, 1);
    check("R10 wrap slot", cap_slot, 2);
    read_status();

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule